// File: doc/BRIEF.md
# Peripheral run-pause state controller

This block holds the operating state of a serial peripheral engine and hands it to the datapath. Software writes a two-bit state code to request one of three states: RESET, RUN or PAUSE. An accepted request does not take effect at once. A settle flag drops for a fixed number of cycles and then rises again, and the new state takes effect on that same edge. Software reads the flag before it writes a request and again after, and gives up after about a hundred polls.

PAUSE can only be entered from RUN. A PAUSE request made in RESET still runs the settle window, but the state stays RESET. The unused code 2 has no effect. A software reset strobe returns the block to RESET at once, with the flag high, and cancels any pending change. A sticky master-ready bit reports that the embedded bus core has finished its configuration. Two enables go to the datapath. The run enable drives transfers, and the pause enable stops the output queue from being consumed.

Top module: `pstate_ctrl`

## Requirements
- R1: After reset, `st_word` reads 0x04. Its fields are: bits [1:0] hold the state (0 = RESET, 1 = RUN, 3 = PAUSE), bit 2 holds the settle flag, bit 4 holds master-ready, and all other bits read 0. Both enables are low after reset.
- R2: A request with code 0, 1 or 3 is accepted when `st_wr` is high and the settle flag is high. The flag then reads 0 for exactly `SETTLE_CYCLES` cycles (default 4), starting after the accepting edge. While the flag is low, the state field keeps its previous value. The flag rises on the same edge that applies the new state.
- R3: A request with code 2 has no effect. The flag stays 1 and the state is unchanged.
- R4: A code 3 (PAUSE) request gives PAUSE only when the current state is RUN or PAUSE. Made in RESET, it still lowers the flag for the settle window, and the state then remains RESET.
- R5: A request presented while the flag is 0 is ignored. The pending change completes as first requested.
- R6: A high `soft_rst` on a clock edge sets the state to RESET, sets the flag to 1, cancels any pending change and clears master-ready. It takes priority over a request and over `core_cfg_done` in the same cycle.
- R7: Master-ready (bit 4) becomes 1 after an edge that samples `core_cfg_done` high. It then stays 1 until `soft_rst` or reset, whatever `core_cfg_done` does.
- R8: `run_en` is 1 only in RUN with the flag at 1. `pause_en` is 1 only in PAUSE with the flag at 1. Both enables are 0 during a settle window.
- R9: RUN, PAUSE and RESET can each be left by a request for RUN (code 1) or RESET (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr | input | 1 | State request write strobe |
| st_code | input | 2 | Requested state code |
| soft_rst | input | 1 | Software reset strobe |
| core_cfg_done | input | 1 | Embedded bus core reports that it is configured |
| st_word | output | 8 | Readable state word: state, settle flag, master-ready |
| run_en | output | 1 | Datapath run enable |
| pause_en | output | 1 | Output-queue freeze enable |

## Verification
Several rules are checked by the assertions on every cycle:
- The state changes only when the settle flag rises or a software reset lands.
- PAUSE is entered only from RUN.
- Code 2 leaves both the state and the flag untouched.
- An accepted request lowers the flag on the next edge.
- A software reset always yields RESET with the flag high and master-ready cleared.

Other behaviour shows only in the bench's scenarios:
- the exact length of the settle window;
- the old state staying visible during that window;
- writes made during the window being dropped;
- master-ready staying set after its input falls;
- the enables following each full sequence of state requests.

// File: rtl/pstate_ctrl.sv
module pstate_ctrl #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr,
  input  logic [1:0] st_code,
  input  logic       soft_rst,
  input  logic       core_cfg_done,
  output logic [7:0] st_word,
  output logic       run_en,
  output logic       pause_en
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [1:0] S_RST   = 2'd0;
  localparam logic [1:0] S_RUN   = 2'd1;
  localparam logic [1:0] S_PAUSE = 2'd3;
  localparam logic [1:0] S_BAD   = 2'd2;

  logic [1:0]    cur_q, tgt_q, tgt_d;
  logic [CW-1:0] cnt_q;
  logic          mrdy_q;

  wire settled = (cnt_q == '0);
  wire req_ok  = st_wr && settled && (st_code != S_BAD);

  always_comb begin
    if (st_code == S_PAUSE)
      tgt_d = (cur_q == S_RUN || cur_q == S_PAUSE) ? S_PAUSE : cur_q;
    else
      tgt_d = st_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= S_RST;
      tgt_q  <= S_RST;
      cnt_q  <= '0;
      mrdy_q <= 1'b0;
    end else if (soft_rst) begin
      cur_q  <= S_RST;
      tgt_q  <= S_RST;
      cnt_q  <= '0;
      mrdy_q <= 1'b0;
    end else begin
      if (core_cfg_done) mrdy_q <= 1'b1;
      if (req_ok) begin
        tgt_q <= tgt_d;
        cnt_q <= CW'(SETTLE_CYCLES);
      end else if (!settled) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) cur_q <= tgt_q;
      end
    end
  end

  assign st_word  = {3'b000, mrdy_q, 1'b0, settled, cur_q};
  assign run_en   = settled && (cur_q == S_RUN);
  assign pause_en = settled && (cur_q == S_PAUSE);

  a_r2_change_on_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_word[1:0] != $past(st_word[1:0])) |->
      ((st_word[2] && !$past(st_word[2])) || $past(soft_rst)));

  a_r2_accept_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && st_word[2] && st_code != 2'd2 && !soft_rst) |=> !st_word[2]);

  a_r3_code2_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && st_word[2] && st_code == 2'd2 && !soft_rst) |=>
      (st_word[2] && $stable(st_word[1:0])));

  a_r4_pause_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st_word[1:0] == 2'd3 && $past(st_word[1:0]) != 2'd3) |->
      ($past(st_word[1:0]) == 2'd1));

  a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st_word[1:0] == 2'd0 && st_word[2] && !st_word[4]));

  a_r8_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !st_word[2] |-> !(run_en || pause_en));
endmodule

// File: tb/tb_pstate_ctrl.sv
module tb_pstate_ctrl;
  localparam int SETTLE = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_wr = 1'b0;
  logic [1:0] st_code = 2'd0;
  logic soft_rst = 1'b0;
  logic core_cfg_done = 1'b0;
  logic [7:0] st_word;
  logic run_en, pause_en;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pstate_ctrl #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_code(st_code),
    .soft_rst(soft_rst), .core_cfg_done(core_cfg_done),
    .st_word(st_word), .run_en(run_en), .pause_en(pause_en));

  // each entry: {requested code, expected state after settling}
  localparam logic [3:0] VEC [8] = '{
    {2'd3, 2'd0}, {2'd1, 2'd1}, {2'd3, 2'd3}, {2'd3, 2'd3},
    {2'd1, 2'd1}, {2'd0, 2'd0}, {2'd1, 2'd1}, {2'd0, 2'd0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] c);
    @(negedge clk);
    st_wr = 1'b1; st_code = c;
    @(negedge clk);
    st_wr = 1'b0;
  endtask

  // called at the negedge right after the accepting edge
  task automatic settle_chk(input logic [1:0] old_s, input logic [1:0] new_s, input string req);
    for (int i = 0; i < SETTLE; i++) begin
      if (i > 0) @(negedge clk);
      chk(st_word[2] == 1'b0 && st_word[1:0] == old_s, {req, " R2 settle window"},
          int'(st_word[2:0]), int'({1'b0, old_s}));
      chk(!run_en && !pause_en, "R8 enables low while settling",
          int'({run_en, pause_en}), 0);
    end
    @(negedge clk);
    chk(st_word[2] && st_word[1:0] == new_s, {req, " settled state"},
        int'(st_word[2:0]), int'({1'b1, new_s}));
    chk(run_en == (new_s == 2'd1) && pause_en == (new_s == 2'd3), "R8 enables",
        int'({run_en, pause_en}), int'({new_s == 2'd1, new_s == 2'd3}));
  endtask

  initial begin
    #(200000 * 20);
    fails++; tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [1:0] prev;
    #35 rst_n = 1'b1;
    @(negedge clk);
    chk(st_word == 8'h04 && !run_en && !pause_en, "R1 reset word", int'(st_word), 4);

    // R3: undefined code
    wr(2'd2);
    chk(st_word == 8'h04, "R3 code 2 ignored", int'(st_word), 4);
    @(negedge clk);
    chk(st_word == 8'h04, "R3 code 2 still ignored", int'(st_word), 4);

    // R4 R9: table walk
    prev = 2'd0;
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][3:2]);
      settle_chk(prev, VEC[i][1:0], "R4 R9 table");
      prev = VEC[i][1:0];
    end

    // R5: write during settle is dropped
    @(negedge clk);
    st_wr = 1'b1; st_code = 2'd1;
    @(negedge clk);
    st_code = 2'd0;
    @(negedge clk);
    st_wr = 1'b0;
    repeat (SETTLE - 1) @(negedge clk);
    chk(st_word[2:0] == 3'b101 && run_en, "R5 late write ignored", int'(st_word[2:0]), 5);

    // R7: master ready sticky
    @(negedge clk); core_cfg_done = 1'b1;
    @(negedge clk); core_cfg_done = 1'b0;
    chk(st_word[4] == 1'b1, "R7 master ready set", int'(st_word[4]), 1);
    repeat (3) @(negedge clk);
    chk(st_word[4] == 1'b1, "R7 master ready sticky", int'(st_word[4]), 1);

    // R6: soft reset mid-settle cancels pending PAUSE
    wr(2'd3);
    chk(st_word[2] == 1'b0, "R2 flag low after PAUSE request", int'(st_word[2]), 0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(st_word == 8'h04 && !run_en && !pause_en, "R6 soft reset", int'(st_word), 4);
    repeat (SETTLE + 1) @(negedge clk);
    chk(st_word == 8'h04, "R6 pending change cancelled", int'(st_word), 4);

    // R6: soft reset beats a simultaneous request and core_cfg_done
    @(negedge clk);
    st_wr = 1'b1; st_code = 2'd1; soft_rst = 1'b1; core_cfg_done = 1'b1;
    @(negedge clk);
    st_wr = 1'b0; soft_rst = 1'b0; core_cfg_done = 1'b0;
    chk(st_word == 8'h04, "R6 priority over request", int'(st_word), 4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule